// File: doc/BRIEF.md
# Modem Input Change Detector

This block watches four active-low modem control lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It keeps an eight-bit status byte. The upper nibble shows the present level of each line, with 1 meaning the line is asserted (pin low). The lower nibble holds sticky change flags. Each pin first passes through a two-flop synchronizer. The synchronized level is then compared with its value one clock earlier, and a difference sets the flag for that line.

The ring indicator line is handled differently from the other three. Its flag sets only when the pin rises from low to high, which marks the end of a ring. The other three lines flag a transition in either direction, so they can also be used as change detectors on general-purpose inputs.

The host reads the byte with a one-cycle read strobe. The flags stay set until such a read clears them. An interrupt request is raised whenever any flag is set and the interrupt enable input is high.

Top module: `modem_change_detect`

## Requirements
- R1: A synchronous reset clears all four change flags, so the read data low nibble is 0 and `irq` is 0.
- R2: Read data bits 7, 6, 5 and 4 show the asserted state of carrier detect, ring indicator, data-set-ready and clear-to-send, in that order. A bit is 1 when its pin is low.
- R3: Flag bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set when the matching pin changes level in either direction.
- R4: Flag bit 2 (ring indicator) sets when its pin goes from low to high. It stays clear when the pin goes from high to low.
- R5: After a pin change, the level bit shows the new state after the second rising clock edge and the flag sets at the third rising clock edge.
- R6: A set flag stays set while no read occurs, whatever the pins do afterwards.
- R7: A read returns the flags as they stand during the strobe cycle. The low nibble is 0 after that clock edge, unless a change coincides with the read (see R8).
- R8: A change detected at the same clock edge as the read strobe leaves its flag set after the read.
- R9: `irq` is high exactly when `irq_en` is high and at least one flag is set. After a read that clears every flag, `irq` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| rd_stb | input | 1 | One-cycle read strobe that clears the flags |
| irq_en | input | 1 | Modem status interrupt enable |
| rd_data | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem status interrupt request |

## Verification
Results appear at different times after a pin change. The level bits follow two rising edges later, the flags three edges later, and `irq` follows the flags, or `irq_en`, in the same cycle. The clearing effect of a read appears one edge after the strobe.

The bench drives every pin change on a falling edge and counts rising edges explicitly before sampling on the next falling edge. One directed test checks the boundary between edges two and three. Another places the read strobe exactly on the edge where a new flag lands.

// File: rtl/msd_pkg.sv
package msd_pkg;

    localparam int NUM_LINES = 4;
    localparam int STAT_W    = 2 * NUM_LINES;

    // line positions inside each nibble of the status byte
    typedef enum int {
        LN_CTS = 0,
        LN_DSR = 1,
        LN_RI  = 2,
        LN_CD  = 3
    } line_e;

    // which transitions count as a change
    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_mode_e;

    typedef struct packed {
        logic [NUM_LINES-1:0] level;  // asserted state (1 = pin low)
        logic [NUM_LINES-1:0] delta;  // sticky change flags
    } status_t;

    function automatic edge_mode_e mode_for(int idx);
        return (idx == LN_RI) ? EDGE_RISE : EDGE_ANY;
    endfunction

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic hit;
        case (mode)
            EDGE_RISE: hit = !prev && cur;
            default:   hit = prev ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int WIDTH   = 4,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= {WIDTH{RST_VAL}};
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= {WIDTH{RST_VAL}};
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/msd_delta.sv
module msd_delta #(
    parameter msd_pkg::edge_mode_e MODE = msd_pkg::EDGE_ANY
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,      // synchronized raw pin level
    input  logic clr,      // read strobe
    output logic flag
);
    logic prev;
    logic hit;

    assign hit = msd_pkg::edge_hit(MODE, prev, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            flag <= 1'b0;
        end else begin
            prev <= lvl;
            flag <= hit | (flag & ~clr);
        end
    end
endmodule

// File: rtl/msd_status.sv
module msd_status
    import msd_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic [LINES-1:0]   sync_lvl,
    input  logic [LINES-1:0]   flags,
    input  logic               irq_en,
    output logic [2*LINES-1:0] rd_data,
    output logic               irq
);
    status_t stat;

    always_comb begin
        stat.level = ~sync_lvl;
        stat.delta = flags;
    end

    assign rd_data = stat;
    assign irq     = irq_en & (|stat.delta);
endmodule

// File: rtl/modem_change_detect.sv
module modem_change_detect
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              cd_n,
    input  logic              rd_stb,
    input  logic              irq_en,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq
);
    logic [NUM_LINES-1:0] pins;
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] flags;

    always_comb begin
        pins         = '1;
        pins[LN_CTS] = cts_n;
        pins[LN_DSR] = dsr_n;
        pins[LN_RI]  = ri_n;
        pins[LN_CD]  = cd_n;
    end

    msd_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pins),
        .dout(sync_lvl)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        msd_delta #(.MODE(mode_for(i))) u_delta (
            .clk (clk),
            .rst (rst),
            .lvl (sync_lvl[i]),
            .clr (rd_stb),
            .flag(flags[i])
        );
    end

    msd_status #(.LINES(NUM_LINES)) u_stat (
        .sync_lvl(sync_lvl),
        .flags   (flags),
        .irq_en  (irq_en),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: rtl/msd_checker.sv
module msd_checker (
    input logic       clk,
    input logic       rst,
    input logic       cts_n,
    input logic       dsr_n,
    input logic       ri_n,
    input logic       cd_n,
    input logic       rd_stb,
    input logic       irq_en,
    input logic [3:0] sync_lvl,
    input logic [7:0] rd_data,
    input logic       irq
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R3: a synchronized change on clear-to-send sets bit 0 one edge later
    assert_cts_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl[0] != $past(sync_lvl[0])) |=> rd_data[0]);

    // R3: carrier detect, either direction
    assert_cd_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl[3] != $past(sync_lvl[3])) |=> rd_data[3]);

    assert_ri_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_lvl[2]) |=> rd_data[2]);

    assert_ri_fall_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_lvl[2]) && rd_stb) |=> !rd_data[2]);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb) |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && $stable(sync_lvl)) |=> (rd_data[3:0] == 4'h0));

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && $stable(sync_lvl)) |=> !irq);

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_level_R2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (rd_data[7:4] == ~$past({cd_n, ri_n, dsr_n, cts_n}, 2)));
endmodule

bind modem_change_detect msd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .cts_n   (cts_n),
    .dsr_n   (dsr_n),
    .ri_n    (ri_n),
    .cd_n    (cd_n),
    .rd_stb  (rd_stb),
    .irq_en  (irq_en),
    .sync_lvl(sync_lvl),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/sim_modem_change_detect.sv
`timescale 1ns/1ps
module sim_modem_change_detect;
    logic clk = 1'b0;
    logic rst;
    logic cts_n, dsr_n, ri_n, cd_n;
    logic rd_stb, irq_en;
    logic [7:0] rd_data;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    modem_change_detect u0 (
        .clk(clk), .rst(rst),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
        .rd_stb(rd_stb), .irq_en(irq_en),
        .rd_data(rd_data), .irq(irq)
    );

    // {pins cd,ri,dsr,cts}[14:11], en[10], rd[9], expected byte[8:1], irq[0]
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {4'b1110, 1'b1, 1'b1, 8'h11, 1'b1},  // R3 cts falls
        {4'b1111, 1'b1, 1'b1, 8'h01, 1'b1},  // R3 cts rises
        {4'b1011, 1'b1, 1'b1, 8'h40, 1'b0},  // R4 ring starts: no flag
        {4'b1111, 1'b1, 1'b1, 8'h04, 1'b1},  // R4 ring ends: flag
        {4'b0101, 1'b0, 1'b0, 8'hAA, 1'b0},  // R3 cd+dsr fall, masked R9
        {4'b0101, 1'b1, 1'b1, 8'hAA, 1'b1},  // R6 held, R9 enabled
        {4'b1111, 1'b1, 1'b0, 8'h0A, 1'b1},  // R3 cd+dsr rise
        {4'b1111, 1'b1, 1'b1, 8'h0A, 1'b1},  // R6 sticky
        {4'b0000, 1'b1, 1'b1, 8'hFB, 1'b1},  // R4 all fall, ri excluded
        {4'b1111, 1'b1, 1'b1, 8'h0F, 1'b1}   // R4 all rise
    };

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_pins(logic [3:0] p);
        {cd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    task automatic do_read();
        @(negedge clk) rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk) rd_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd_stb = 1'b0; irq_en = 1'b1;
        set_pins(4'b1111);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 reset", {rd_data, irq}, 9'h000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_pins(VEC[i][14:11]);
            irq_en = VEC[i][10];
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("R2/R3/R4/R9 vec%0d", i), {rd_data, irq}, VEC[i][8:0]);
            if (VEC[i][9]) begin
                rd_stb = 1'b1;
                @(posedge clk);
                @(negedge clk) rd_stb = 1'b0;
                check($sformatf("R7/R9 clear vec%0d", i), {rd_data, irq},
                      {VEC[i][8:5], 4'h0, 1'b0});
            end
        end

        // R5: level after two edges, flag after the third
        @(negedge clk) set_pins(4'b1110);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 level at edge two", {1'b0, rd_data}, {1'b0, 8'h10});
        @(posedge clk);
        @(negedge clk);
        check("R5 flag at edge three", {1'b0, rd_data}, {1'b0, 8'h11});
        do_read();

        // R8: dsr flag pending, cts change lands on the read edge
        set_pins(4'b1100);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 setup", {rd_data, irq}, {8'h32, 1'b1});
        set_pins(4'b1101);
        repeat (2) @(posedge clk);
        @(negedge clk) rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk) rd_stb = 1'b0;
        check("R8 coincident change kept", {rd_data, irq}, {8'h21, 1'b1});
        do_read();
        check("R7 cleared after second read", {rd_data, irq}, {8'h20, 1'b0});

        // R1: reset with a flag pending
        set_pins(4'b0111);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 cd before reset", {rd_data, irq}, {8'h8A, 1'b1});
        rst = 1'b1;
        set_pins(4'b1111);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 reset clears flags", {rd_data, irq}, 9'h000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule